// File: doc/BRIEF.md
# Partial-Scan Test Sequencer

This block runs the test schedule of a design in which only part of the flip-flops sit on a serial scan chain. It drives two clock enables: one for the scanned group and one for the flip-flops that are not on the chain. It also drives a select that steers the chain between its serial shift path and its functional path. A test starts with a chain integrity flush. This is a fixed repeating pattern shifted through the chain for four cycles more than the chain length. Then, for each test vector, the block shifts in the chain state, applies the primary-input vector for one functional capture cycle, and moves on. A final scan-out unloads the state captured by the last vector.

Scan-in bits and primary-input vectors arrive over valid/ready handshakes. While the data the schedule needs is missing, the sequencer holds both clock enables low, and the test does not advance. The state captured by vector k is unloaded during the scan-in of vector k+1, on the same shift cycles. Each unloaded bit is presented with a strobe. A counter tracks test cycles, meaning the cycles in which a clock enable is high. The done indication rises once this counter reaches (V+2)·N + V + 4, where N is the chain length and V is the vector count.

Top module: `pscan_seq`

## Requirements
- R1: In a capture cycle both `clk_en_scan` and `clk_en_func` are high and `test_ctl` is 0. In every flush or shift cycle only `clk_en_scan` is high, and `test_ctl` is 1.
- R2: After an accepted start, the flush lasts exactly N+4 cycles. In flush cycle i (counted from 0), `scan_din` equals bit 1 of i, which gives the pattern 0,0,1,1,0,0,1,1,…
- R3: Each vector is preceded by N scan-in cycles. Each of these cycles takes one `si_bit` when `si_valid` and `si_ready` are both high, and passes it to `scan_din`.
- R4: After each scan-in comes exactly one capture cycle. It takes place when `pi_valid` and `pi_ready` are both high, and `pi_out` then equals `pi_vec`.
- R5: After the capture of the last vector come N scan-out cycles. In these cycles `scan_din` is 0 and `so_valid` is 1.
- R6: `cycle_cnt` rises by one after every cycle with `clk_en_scan` high. When the schedule ends, `cycle_cnt` equals (V+2)·N+V+4 and `done` is 1.
- R7: During the scan-in of vector 0, `so_valid` stays 0. During the scan-in of every later vector, each shift cycle has `so_valid` at 1 and `so_bit` equal to `chain_so`.
- R8: While the schedule waits for a scan-in bit or a vector that is not valid, both clock enables are 0 and `cycle_cnt` holds. `si_ready` is 1 only in the scan-in state, and `pi_ready` is 1 only in the capture state.
- R9: A synchronous `rst` sets `mode` to 0, both enables to 0, `cycle_cnt` to 0 and `done` to 0. This holds whatever the state was before.
- R10: `mode` encodes the state as follows: 0 idle, 1 flush, 2 scan-in, 3 capture, 4 scan-out, 5 finished.
- R11: `start` is accepted in the idle or finished state. It latches `chain_len` (N, 1 to 64) and `vec_count` (V, 1 to 1024), clears `cycle_cnt`, and enters flush on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a test schedule |
| chain_len | input | 7 | Scanned flip-flop count N |
| vec_count | input | 11 | Vector count V |
| si_valid | input | 1 | Scan-in bit available |
| si_bit | input | 1 | Scan-in bit |
| si_ready | output | 1 | Sequencer wants a scan-in bit |
| pi_valid | input | 1 | Primary-input vector available |
| pi_vec | input | PI_W | Primary-input vector |
| pi_ready | output | 1 | Sequencer wants a vector |
| chain_so | input | 1 | Serial output of the scan chain |
| scan_din | output | 1 | Serial input to the scan chain |
| test_ctl | output | 1 | 1 selects the shift path, 0 the functional path |
| clk_en_scan | output | 1 | Clock enable, scanned flip-flops |
| clk_en_func | output | 1 | Clock enable, non-scanned flip-flops |
| pi_out | output | PI_W | Vector applied to the logic |
| so_valid | output | 1 | Unloaded bit strobe |
| so_bit | output | 1 | Unloaded bit |
| mode | output | 3 | State code |
| cycle_cnt | output | 17 | Test cycles since start |
| done | output | 1 | Schedule finished |

## Verification
The hardest situation to reach is a stall that falls exactly on a phase boundary. Examples are a missing scan-in bit on the first shift after a capture, or a missing vector right after the last scan-in bit. These are the points where state, bit count and vector index all change together. The bench withholds the valid inputs at random on a large share of cycles across runs with chain lengths of 1, 5 and 64. With a chain of 1, every scan-in is also a boundary. A scan chain model in the bench feeds `chain_so`, so the unloaded bits can be traced back to the bits shifted in one vector earlier.

// File: rtl/pscan_seq_pkg.sv
package pscan_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FLUSH = 3'd1,
    ST_SIN   = 3'd2,
    ST_CAP   = 3'd3,
    ST_SOUT  = 3'd4,
    ST_FIN   = 3'd5
  } seq_state_e;

  // Length of the whole schedule in test cycles.
  function automatic int unsigned test_cycles(input int unsigned n, input int unsigned v);
    return (v + 2) * n + v + 4;
  endfunction

  // Flush pattern 0,0,1,1 repeating.
  function automatic logic flush_bit(input int unsigned idx);
    return idx[1];
  endfunction

endpackage

// File: rtl/pscan_cfg.sv
module pscan_cfg
  import pscan_seq_pkg::*;
#(
  parameter int CHAIN_W = 7,
  parameter int VEC_W   = 11,
  parameter int CNT_W   = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic [CHAIN_W-1:0] chain_len,
  input  logic [VEC_W-1:0]   vec_count,
  output logic [CHAIN_W-1:0] n_q,
  output logic [VEC_W-1:0]   v_q,
  output logic [CNT_W-1:0]   total_cycles
);

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q <= '0;
      v_q <= '0;
    end else if (accept) begin
      n_q <= chain_len;
      v_q <= vec_count;
    end
  end

  assign total_cycles = CNT_W'(test_cycles(32'(n_q), 32'(v_q)));

endmodule

// File: rtl/pscan_fsm.sv
module pscan_fsm
  import pscan_seq_pkg::*;
#(
  parameter int CHAIN_W = 7,
  parameter int VEC_W   = 11,
  parameter int BIT_W   = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [CHAIN_W-1:0] n_q,
  input  logic [VEC_W-1:0]   v_q,
  input  logic               si_valid,
  input  logic               pi_valid,
  output seq_state_e         st,
  output logic               accept,
  output logic               fire,
  output logic [BIT_W-1:0]   bit_cnt,
  output logic [VEC_W-1:0]   vec_idx
);

  logic flush_end, shift_end, last_vec;

  assign accept    = start && (st == ST_IDLE || st == ST_FIN);
  assign flush_end = (bit_cnt == BIT_W'(n_q) + BIT_W'(3));
  assign shift_end = (bit_cnt == BIT_W'(n_q) - BIT_W'(1));
  assign last_vec  = (vec_idx == v_q - VEC_W'(1));

  always_comb begin
    case (st)
      ST_FLUSH, ST_SOUT: fire = 1'b1;
      ST_SIN:            fire = si_valid;
      ST_CAP:            fire = pi_valid;
      default:           fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      vec_idx <= '0;
    end else begin
      case (st)
        ST_IDLE, ST_FIN: begin
          if (accept) begin
            st      <= ST_FLUSH;
            bit_cnt <= '0;
            vec_idx <= '0;
          end
        end
        ST_FLUSH: begin
          if (flush_end) begin
            st      <= ST_SIN;
            bit_cnt <= '0;
          end else begin
            bit_cnt <= bit_cnt + BIT_W'(1);
          end
        end
        ST_SIN: begin
          if (si_valid) begin
            if (shift_end) begin
              st      <= ST_CAP;
              bit_cnt <= '0;
            end else begin
              bit_cnt <= bit_cnt + BIT_W'(1);
            end
          end
        end
        ST_CAP: begin
          if (pi_valid) begin
            st      <= last_vec ? ST_SOUT : ST_SIN;
            vec_idx <= vec_idx + VEC_W'(1);
          end
        end
        ST_SOUT: begin
          if (shift_end) begin
            st      <= ST_FIN;
            bit_cnt <= '0;
          end else begin
            bit_cnt <= bit_cnt + BIT_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pscan_cycle_ctr.sv
module pscan_cycle_ctr #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (step)    count <= count + CNT_W'(1);
  end

endmodule

// File: rtl/pscan_datapath.sv
module pscan_datapath
  import pscan_seq_pkg::*;
#(
  parameter int BIT_W = 7,
  parameter int VEC_W = 11,
  parameter int PI_W  = 8
) (
  input  seq_state_e        st,
  input  logic              fire,
  input  logic [BIT_W-1:0]  bit_cnt,
  input  logic [VEC_W-1:0]  vec_idx,
  input  logic              si_bit,
  input  logic [PI_W-1:0]   pi_vec,
  input  logic              chain_so,
  output logic              scan_din,
  output logic              test_ctl,
  output logic              clk_en_scan,
  output logic              clk_en_func,
  output logic [PI_W-1:0]   pi_out,
  output logic              so_valid,
  output logic              so_bit,
  output logic              si_ready,
  output logic              pi_ready
);

  logic shifting;

  assign shifting    = (st == ST_FLUSH) || (st == ST_SIN) || (st == ST_SOUT);
  assign test_ctl    = shifting;
  assign clk_en_scan = fire;
  assign clk_en_func = fire && (st == ST_CAP);
  assign si_ready    = (st == ST_SIN);
  assign pi_ready    = (st == ST_CAP);
  assign pi_out      = (st == ST_CAP) ? pi_vec : '0;

  always_comb begin
    case (st)
      ST_FLUSH: scan_din = flush_bit(32'(bit_cnt));
      ST_SIN:   scan_din = si_bit;
      default:  scan_din = 1'b0;
    endcase
  end

  assign so_valid = (st == ST_SOUT) || (st == ST_SIN && fire && vec_idx != '0);
  assign so_bit   = so_valid ? chain_so : 1'b0;

endmodule

// File: rtl/pscan_seq.sv
module pscan_seq
  import pscan_seq_pkg::*;
#(
  parameter int MAX_CHAIN = 64,
  parameter int MAX_VEC   = 1024,
  parameter int PI_W      = 8,
  localparam int CHAIN_W  = $clog2(MAX_CHAIN + 1),
  localparam int VEC_W    = $clog2(MAX_VEC + 1),
  localparam int BIT_W    = $clog2(MAX_CHAIN + 5),
  localparam int CNT_W    = $clog2(test_cycles(MAX_CHAIN, MAX_VEC) + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [CHAIN_W-1:0] chain_len,
  input  logic [VEC_W-1:0]   vec_count,
  input  logic               si_valid,
  input  logic               si_bit,
  output logic               si_ready,
  input  logic               pi_valid,
  input  logic [PI_W-1:0]    pi_vec,
  output logic               pi_ready,
  input  logic               chain_so,
  output logic               scan_din,
  output logic               test_ctl,
  output logic               clk_en_scan,
  output logic               clk_en_func,
  output logic [PI_W-1:0]    pi_out,
  output logic               so_valid,
  output logic               so_bit,
  output logic [2:0]         mode,
  output logic [CNT_W-1:0]   cycle_cnt,
  output logic               done
);

  seq_state_e         st;
  logic               accept, fire;
  logic [BIT_W-1:0]   bit_cnt;
  logic [VEC_W-1:0]   vec_idx;
  logic [CHAIN_W-1:0] n_q;
  logic [VEC_W-1:0]   v_q;
  logic [CNT_W-1:0]   total_cycles;

  pscan_cfg #(.CHAIN_W(CHAIN_W), .VEC_W(VEC_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst), .accept(accept),
    .chain_len(chain_len), .vec_count(vec_count),
    .n_q(n_q), .v_q(v_q), .total_cycles(total_cycles)
  );

  pscan_fsm #(.CHAIN_W(CHAIN_W), .VEC_W(VEC_W), .BIT_W(BIT_W)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .n_q(n_q), .v_q(v_q),
    .si_valid(si_valid), .pi_valid(pi_valid),
    .st(st), .accept(accept), .fire(fire), .bit_cnt(bit_cnt), .vec_idx(vec_idx)
  );

  pscan_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .clear(accept), .step(clk_en_scan), .count(cycle_cnt)
  );

  pscan_datapath #(.BIT_W(BIT_W), .VEC_W(VEC_W), .PI_W(PI_W)) u_dp (
    .st(st), .fire(fire), .bit_cnt(bit_cnt), .vec_idx(vec_idx),
    .si_bit(si_bit), .pi_vec(pi_vec), .chain_so(chain_so),
    .scan_din(scan_din), .test_ctl(test_ctl),
    .clk_en_scan(clk_en_scan), .clk_en_func(clk_en_func),
    .pi_out(pi_out), .so_valid(so_valid), .so_bit(so_bit),
    .si_ready(si_ready), .pi_ready(pi_ready)
  );

  assign mode = st;
  assign done = (st == ST_FIN);

endmodule

// File: rtl/pscan_seq_chk.sv
module pscan_seq_chk #(
  parameter int CNT_W = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             accept,
  input logic [2:0]       mode,
  input logic             clk_en_scan,
  input logic             clk_en_func,
  input logic             test_ctl,
  input logic             si_valid,
  input logic             pi_valid,
  input logic             so_valid,
  input logic [CNT_W-1:0] cycle_cnt,
  input logic [CNT_W-1:0] total_cycles,
  input logic             done
);

  AST_FUNC_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
    clk_en_func |-> (clk_en_scan && !test_ctl)); // R1
  AST_SHIFT_SCAN_ONLY: assert property (@(posedge clk) disable iff (rst)
    (clk_en_scan && test_ctl) |-> !clk_en_func); // R1
  AST_STALL_SIN: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd2 && !si_valid) |-> (!clk_en_scan && !clk_en_func)); // R8
  AST_STALL_CAP: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd3 && !pi_valid) |-> !clk_en_scan); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (clk_en_scan && !accept) |=> (cycle_cnt == $past(cycle_cnt) + CNT_W'(1))); // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_scan && !accept) |=> $stable(cycle_cnt)); // R8
  AST_DONE_TOTAL: assert property (@(posedge clk) disable iff (rst)
    done |-> (cycle_cnt == total_cycles)); // R6
  AST_START_FLUSH: assert property (@(posedge clk) disable iff (rst)
    accept |=> (mode == 3'd1 && cycle_cnt == '0)); // R11
  AST_UNLOAD_SHIFTS: assert property (@(posedge clk) disable iff (rst)
    so_valid |-> (clk_en_scan && test_ctl)); // R7
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0 || mode == 3'd5) |-> !clk_en_scan); // R9

endmodule

bind pscan_seq pscan_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .accept(accept), .mode(mode),
  .clk_en_scan(clk_en_scan), .clk_en_func(clk_en_func), .test_ctl(test_ctl),
  .si_valid(si_valid), .pi_valid(pi_valid), .so_valid(so_valid),
  .cycle_cnt(cycle_cnt), .total_cycles(total_cycles), .done(done)
);

// File: tb/pscan_seq_tb.sv
`timescale 1ns/1ps
module pscan_seq_tb;

  localparam int PI_W = 8;

  logic clk = 0, rst = 1, start = 0;
  logic [6:0]  chain_len = '0;
  logic [10:0] vec_count = '0;
  logic si_valid = 0, si_bit = 0, pi_valid = 0, chain_so = 0;
  logic [PI_W-1:0] pi_vec = '0;
  logic si_ready, pi_ready, scan_din, test_ctl, clk_en_scan, clk_en_func;
  logic [PI_W-1:0] pi_out;
  logic so_valid, so_bit, done;
  logic [2:0] mode;
  logic [16:0] cycle_cnt;

  pscan_seq u_dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected test-cycle stream: kind 1 flush, 2 scan-in, 3 capture, 4 scan-out
  typedef struct { int kind; bit din; logic [PI_W-1:0] pi; bit sov; } ent_t;
  ent_t exp_q[$];
  bit chain [0:63];
  bit si_bits [0:7][0:63];
  logic [PI_W-1:0] pis [0:7];

  task automatic run_test(input int n, input int v, input int stall_pct, input int abort_after);
    ent_t e;
    int consumed = 0, guard = 0, si_k = 0, si_j = 0, cap_k = 0;
    bit do_shift, do_inv, shin;
    exp_q.delete();
    for (int k = 0; k < v; k++) begin
      pis[k] = PI_W'($urandom);
      for (int j = 0; j < n; j++) si_bits[k][j] = 1'($urandom);
    end
    for (int c = 0; c < n + 4; c++) begin
      e.kind = 1; e.din = 1'((c / 2) % 2); e.pi = '0; e.sov = 0; exp_q.push_back(e);
    end
    for (int k = 0; k < v; k++) begin
      for (int j = 0; j < n; j++) begin
        e.kind = 2; e.din = si_bits[k][j]; e.pi = '0; e.sov = (k > 0); exp_q.push_back(e);
      end
      e.kind = 3; e.din = 0; e.pi = pis[k]; e.sov = 0; exp_q.push_back(e);
    end
    for (int j = 0; j < n; j++) begin
      e.kind = 4; e.din = 0; e.pi = '0; e.sov = 1; exp_q.push_back(e);
    end
    for (int i = 0; i < 64; i++) chain[i] = 0;

    @(negedge clk);
    start = 1; chain_len = 7'(n); vec_count = 11'(v);
    #1;
    chk(!clk_en_scan && !clk_en_func, "R11 no enables on start cycle", int'(clk_en_scan), 0);
    @(negedge clk);
    start = 0;
    while (exp_q.size() > 0 && guard < 20000 && (abort_after == 0 || consumed < abort_after)) begin
      guard++;
      e = exp_q[0];
      si_valid = ($urandom % 100) >= stall_pct;
      pi_valid = ($urandom % 100) >= stall_pct;
      si_bit   = (e.kind == 2) ? si_bits[si_k][si_j] : 1'($urandom);
      pi_vec   = pis[cap_k];
      chain_so = chain[n-1];
      #1;
      begin
        bit avail;
        avail = (e.kind == 2) ? si_valid : (e.kind == 3) ? pi_valid : 1'b1;
        chk(mode == 3'(e.kind), "R10 mode", int'(mode), e.kind);
        chk(clk_en_scan == avail, "R8 scan enable", int'(clk_en_scan), int'(avail));
        chk(clk_en_func == (avail && e.kind == 3), "R1 func enable", int'(clk_en_func), int'(avail && e.kind == 3));
        chk(si_ready == (e.kind == 2), "R8 si_ready", int'(si_ready), int'(e.kind == 2));
        chk(pi_ready == (e.kind == 3), "R8 pi_ready", int'(pi_ready), int'(e.kind == 3));
        chk(test_ctl == (e.kind != 3), "R1 test_ctl", int'(test_ctl), int'(e.kind != 3));
        chk(cycle_cnt == 17'(consumed), "R6 cycle count", int'(cycle_cnt), consumed);
        do_shift = 0; do_inv = 0; shin = 0;
        if (avail) begin
          if (e.kind == 1) chk(scan_din == e.din, "R2 flush pattern", int'(scan_din), int'(e.din));
          if (e.kind == 2) chk(scan_din == e.din, "R3 scan-in data", int'(scan_din), int'(e.din));
          if (e.kind == 4) chk(scan_din == 1'b0, "R5 scan-out fill", int'(scan_din), 0);
          if (e.kind == 3) chk(pi_out == e.pi, "R4 capture vector", int'(pi_out), int'(e.pi));
          chk(so_valid == e.sov, (e.kind == 4) ? "R5 unload strobe" : "R7 unload strobe",
              int'(so_valid), int'(e.sov));
          if (e.sov) chk(so_bit == chain[n-1], "R7 unload bit", int'(so_bit), int'(chain[n-1]));
          if (e.kind == 3) begin do_inv = pis[cap_k][0]; cap_k++; si_k = cap_k; si_j = 0; end
          else begin do_shift = 1; shin = e.din; end
          if (e.kind == 2) si_j++;
          void'(exp_q.pop_front());
          consumed++;
        end
      end
      @(posedge clk);
      #1;
      if (do_shift) begin
        for (int i = 63; i > 0; i--) chain[i] = chain[i-1];
        chain[0] = shin;
      end
      if (do_inv) for (int i = 0; i < 64; i++) chain[i] = ~chain[i];
      @(negedge clk);
      #0;
    end
    if (guard >= 20000) chk(0, "R6 schedule did not finish", guard, 0);
    if (abort_after == 0) begin
      si_valid = 0; pi_valid = 0;
      #1;
      chk(done == 1'b1, "R6 done", int'(done), 1);
      chk(mode == 3'd5, "R10 finished mode", int'(mode), 5);
      chk(cycle_cnt == 17'((v + 2) * n + v + 4), "R6 total formula", int'(cycle_cnt), (v + 2) * n + v + 4);
      chk(!clk_en_scan && !clk_en_func, "R6 quiet when finished", int'(clk_en_scan), 0);
      @(posedge clk); #1;
      chk(cycle_cnt == 17'((v + 2) * n + v + 4), "R6 count holds", int'(cycle_cnt), (v + 2) * n + v + 4);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(mode == 3'd0, "R9 reset mode", int'(mode), 0);
    chk(!clk_en_scan && !clk_en_func, "R9 reset enables", int'(clk_en_scan), 0);
    chk(cycle_cnt == 0 && !done, "R9 reset count", int'(cycle_cnt), 0);
    @(negedge clk); rst = 0;
    run_test(5, 3, 40, 0);
    run_test(1, 2, 50, 0);
    run_test(64, 4, 20, 0);
    run_test(3, 1, 0, 0);
    run_test(8, 2, 30, 25);
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    chk(mode == 3'd0, "R9 mid-run reset mode", int'(mode), 0);
    chk(!clk_en_scan && !clk_en_func, "R9 mid-run reset enables", int'(clk_en_scan), 0);
    chk(cycle_cnt == 0 && !done, "R9 mid-run reset count", int'(cycle_cnt), 0);
    @(negedge clk); rst = 0;
    run_test(2, 2, 10, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule